// File: doc/BRIEF.md
# Aliased Set/Clear Control Register File

This block is a target on a simple 64-bit register bus. It stores twelve 64-bit words: six control words, two configuration words, a status word, a mask word, a protect-mode word and an atomic-lock word. Software reads and writes them through a single-cycle request. Each control and configuration word can also be changed through two extra write-only addresses. One ORs the write data into the word. The other clears the word's bits wherever the write data holds a one. A bit can therefore be changed without a read-modify-write sequence.

The word index is the byte address shifted right by three, and every access moves one whole 64-bit word. A response comes back on the cycle after each request. A read of a write-only alias gets all ones and a guest-error pulse. Any access to an index that holds no register gets an unimplemented-access pulse: a read returns all ones, and a write is dropped. The stored bits drive nothing inside this block.

Top module: `alias_regfile`

## Requirements
- R1: After synchronous active-high reset, every stored word reads back as zero.
- R2: A write to a primary index replaces the whole word, and a later read of that index returns it. The control words sit at indices 0x00 to 0x05, the configuration words at 0x08 and 0x09, status at 0x100, mask at 0x101, protect-mode at 0x3FE and atomic-lock at 0x3FF. The index is the byte address shifted right by 3.
- R3: A write to index 0x10+i ORs the write data into control word i. A write to 0x18 or 0x19 does the same for configuration word 0 or 1.
- R4: A write to index 0x20+i clears the bits of control word i wherever the write data is one. A write to 0x28 or 0x29 does the same for configuration word 0 or 1.
- R5: A read of any OR or clear alias returns all ones and pulses err_guest for one cycle. It changes no stored word.
- R6: A read of an index that holds no register and is no alias returns all ones and pulses err_unimp.
- R7: A write to such an index changes no stored word and pulses err_unimp.
- R8: Any access whose address bits [2:0] are nonzero is treated as unmapped (R6, R7).
- R9: rsp_valid is high exactly on the cycle after each request. A write response carries zero data. A write to a mapped address raises no error.
- R10: A write or alias write changes only the addressed word.
- R11: err_guest and err_unimp are never high together, and they rise only together with rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 64 | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data (zero on write responses) |
| rsp_err_guest | output | 1 | Read of a write-only alias |
| rsp_err_unimp | output | 1 | Access to an unmapped or misaligned address |

## Verification
The response properties assume that req_valid is low during the last reset cycle. A request taken during reset would produce no response, yet the first property after reset would expect one. The bench keeps req_valid low for the whole reset. The properties also assume that the request signals are stable around the rising edge. The bench therefore drives every input on the falling edge. A shadow model of the twelve words predicts every response. The stimulus includes back-to-back requests, so one response follows another with no idle gap.

// File: rtl/arf_pkg.sv
package arf_pkg;

    // index map (index = byte address >> 3)
    localparam int IDX_CFG_BASE = 'h08;
    localparam int IDX_SET_OFS  = 'h10;
    localparam int IDX_CLR_OFS  = 'h20;
    localparam int IDX_STAT     = 'h100;
    localparam int IDX_MASK     = 'h101;
    localparam int IDX_PROT     = 'h3FE;
    localparam int IDX_LOCK     = 'h3FF;

    localparam int N_MISC = 4;
    localparam int SLOT_W = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_FULL = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } wop_e;

    typedef struct packed {
        logic              mapped;
        logic              alias_hit;
        logic [SLOT_W-1:0] slot;
        wop_e              op;
    } dec_t;

endpackage

// File: rtl/arf_decode.sv
module arf_decode
    import arf_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int N_CTRL = 6,
    parameter int N_CFG  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int IDX_W    = ADDR_W - 3;
    localparam int MISC_BASE = N_CTRL + N_CFG;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:3];

    always_comb begin
        dec = '{mapped: 1'b0, alias_hit: 1'b0, slot: '0, op: OP_NONE};
        if (addr[2:0] == 3'b000) begin
            for (int i = 0; i < N_CTRL; i++) begin
                if (idx == IDX_W'(i)) begin
                    dec = '{mapped: 1'b1, alias_hit: 1'b0, slot: SLOT_W'(i), op: OP_FULL};
                end
                if (idx == IDX_W'(i + IDX_SET_OFS)) begin
                    dec = '{mapped: 1'b1, alias_hit: 1'b1, slot: SLOT_W'(i), op: OP_SET};
                end
                if (idx == IDX_W'(i + IDX_CLR_OFS)) begin
                    dec = '{mapped: 1'b1, alias_hit: 1'b1, slot: SLOT_W'(i), op: OP_CLR};
                end
            end
            for (int j = 0; j < N_CFG; j++) begin
                if (idx == IDX_W'(IDX_CFG_BASE + j)) begin
                    dec = '{mapped: 1'b1, alias_hit: 1'b0, slot: SLOT_W'(N_CTRL + j), op: OP_FULL};
                end
                if (idx == IDX_W'(IDX_CFG_BASE + IDX_SET_OFS + j)) begin
                    dec = '{mapped: 1'b1, alias_hit: 1'b1, slot: SLOT_W'(N_CTRL + j), op: OP_SET};
                end
                if (idx == IDX_W'(IDX_CFG_BASE + IDX_CLR_OFS + j)) begin
                    dec = '{mapped: 1'b1, alias_hit: 1'b1, slot: SLOT_W'(N_CTRL + j), op: OP_CLR};
                end
            end
            if (idx == IDX_W'(IDX_STAT))
                dec = '{mapped: 1'b1, alias_hit: 1'b0, slot: SLOT_W'(MISC_BASE + 0), op: OP_FULL};
            if (idx == IDX_W'(IDX_MASK))
                dec = '{mapped: 1'b1, alias_hit: 1'b0, slot: SLOT_W'(MISC_BASE + 1), op: OP_FULL};
            if (idx == IDX_W'(IDX_PROT))
                dec = '{mapped: 1'b1, alias_hit: 1'b0, slot: SLOT_W'(MISC_BASE + 2), op: OP_FULL};
            if (idx == IDX_W'(IDX_LOCK))
                dec = '{mapped: 1'b1, alias_hit: 1'b0, slot: SLOT_W'(MISC_BASE + 3), op: OP_FULL};
        end
    end

endmodule

// File: rtl/arf_word.sv
module arf_word
    import arf_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter bit HAS_ALIAS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wop_e              op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] q_next;

    generate
        if (HAS_ALIAS) begin : g_alias
            always_comb begin
                unique case (op)
                    OP_FULL: q_next = wdata;
                    OP_SET:  q_next = q | wdata;
                    OP_CLR:  q_next = q & ~wdata;
                    default: q_next = q;
                endcase
            end
        end else begin : g_plain
            always_comb q_next = (op == OP_FULL) ? wdata : q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= q_next;
    end

endmodule

// File: rtl/arf_resp.sv
module arf_resp
    import arf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              mapped,
    input  logic              alias_hit,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err_guest,
    output logic              rsp_err_unimp
);
    logic              is_read;
    logic [DATA_W-1:0] rdata_n;

    assign is_read = req_valid & ~req_write;

    always_comb begin
        if (!is_read)                  rdata_n = '0;
        else if (!mapped || alias_hit) rdata_n = '1;
        else                           rdata_n = rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            rsp_err_guest <= 1'b0;
            rsp_err_unimp <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_rdata     <= rdata_n;
            rsp_err_guest <= is_read & mapped & alias_hit;
            rsp_err_unimp <= req_valid & ~mapped;
        end
    end

endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
    import arf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64,
    parameter int N_CTRL = 6,
    parameter int N_CFG  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err_guest,
    output logic              rsp_err_unimp
);
    localparam int N_ALIASED = N_CTRL + N_CFG;
    localparam int N_WORDS   = N_ALIASED + N_MISC;

    dec_t              dec;
    logic [DATA_W-1:0] word_q [N_WORDS];
    logic [DATA_W-1:0] rd_word;

    arf_decode #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .N_CFG(N_CFG)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        logic wr_en;
        assign wr_en = req_valid & req_write & dec.mapped & (dec.slot == SLOT_W'(k));
        arf_word #(.DATA_W(DATA_W), .HAS_ALIAS(k < N_ALIASED)) u_word (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .op    (dec.op),
            .wdata (req_wdata),
            .q     (word_q[k])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (dec.slot == SLOT_W'(k)) rd_word = word_q[k];
        end
    end

    arf_resp #(.DATA_W(DATA_W)) u_resp (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .mapped        (dec.mapped),
        .alias_hit     (dec.alias_hit),
        .rd_word       (rd_word),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_err_guest (rsp_err_guest),
        .rsp_err_unimp (rsp_err_unimp)
    );

endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err_guest,
    input logic              rsp_err_unimp
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R9
    AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == '0)); // R9
    AST_GUEST_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_err_guest); // R5
    AST_ERR_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> (!(rsp_err_guest || rsp_err_unimp) || rsp_rdata == '1)); // R6
    AST_MISALIGNED_UNIMP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[2:0] != 3'b000) |=> rsp_err_unimp); // R8
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rsp_err_guest && rsp_err_unimp)); // R11
    AST_ERR_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
        (rsp_err_guest || rsp_err_unimp) |-> rsp_valid); // R11
endmodule

bind alias_regfile alias_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_err_guest (rsp_err_guest),
    .rsp_err_unimp (rsp_err_unimp)
);

// File: tb/sim_alias_regfile.sv
`timescale 1ns/1ps
module sim_alias_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [63:0] req_addr  = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err_guest;
    logic        rsp_err_unimp;

    always #2.5 clk = ~clk;

    alias_regfile u0 (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_err_guest (rsp_err_guest),
        .rsp_err_unimp (rsp_err_unimp)
    );

    typedef struct {
        logic [63:0] data;
        logic        eg;
        logic        eu;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] shadow [12];
    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    // primary word indices, in slot order
    int prim_idx [12] = '{'h00, 'h01, 'h02, 'h03, 'h04, 'h05,
                          'h08, 'h09, 'h100, 'h101, 'h3FE, 'h3FF};

    // op: 0 unmapped, 1 full, 2 OR alias, 3 clear alias
    function automatic void model_map(input logic [63:0] a, output int slot, output int op);
        logic [63:0] ix;
        ix   = a >> 3;
        slot = 0;
        op   = 0;
        if (a[2:0] != 3'b000) return;
        for (int s = 0; s < 12; s++) begin
            if (ix == 64'(prim_idx[s])) begin slot = s; op = 1; end
            if (s < 8 && ix == 64'(prim_idx[s] + 'h10)) begin slot = s; op = 2; end
            if (s < 8 && ix == 64'(prim_idx[s] + 'h20)) begin slot = s; op = 3; end
        end
    endfunction

    task automatic access(input bit wr, input logic [63:0] a, input logic [63:0] d, input string tag);
        int   slot, op;
        exp_t e;
        model_map(a, slot, op);
        e.tag = tag;
        if (wr) begin
            e.data = '0; e.eg = 1'b0; e.eu = (op == 0);
            case (op)
                1: shadow[slot] = d;
                2: shadow[slot] = shadow[slot] | d;
                3: shadow[slot] = shadow[slot] & ~d;
                default: ;
            endcase
        end else begin
            e.eg   = (op >= 2);
            e.eu   = (op == 0);
            e.data = (op == 1) ? shadow[slot] : '1;
        end
        @(negedge clk);
        sb_q.push_back(e);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
        end
    endtask

    task automatic wr_idx(input int ix, input logic [63:0] d, input string tag);
        access(1'b1, 64'(ix) << 3, d, tag);
    endtask

    task automatic rd_idx(input int ix, input string tag);
        access(1'b0, 64'(ix) << 3, '0, tag);
    endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < 12; s++) rd_idx(prim_idx[s], tag);
    endtask

    // monitor: compare each response with the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                n_vec++;
                if (sb_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: response with nothing pending (rdata %h, expected none)", rsp_rdata);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (rsp_rdata !== e.data || rsp_err_guest !== e.eg || rsp_err_unimp !== e.eu) begin
                        n_fail++;
                        $display("FAIL %s: got data %h eg %0b eu %0b, expected data %h eg %0b eu %0b",
                                 e.tag, rsp_rdata, rsp_err_guest, rsp_err_unimp, e.data, e.eg, e.eu);
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run hung (actual not finished, expected finished)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 12; s++) shadow[s] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rsp_valid %0b after reset, expected 0", rsp_valid);
        end

        // R1: reset values
        read_all("R1");

        // R2: plain writes to every primary word, back to back
        for (int s = 0; s < 12; s++)
            wr_idx(prim_idx[s], {32'hA5A5_0000 + 32'(s), 32'h1234_5678 ^ 32'(s * 'h1111)}, "R2");
        read_all("R2");

        // R10: one write, everything else untouched
        wr_idx('h03, 64'hDEAD_BEEF_0000_FFFF, "R10");
        read_all("R10");
        wr_idx('h08, 64'h0, "R10");
        read_all("R10");

        // R3: OR aliases on control and configuration words
        for (int i = 0; i < 6; i++) wr_idx('h10 + i, 64'h8000_0000_0000_0001 << i, "R3");
        wr_idx('h18, 64'h0F0F, "R3");
        wr_idx('h19, 64'hF000_0000_0000_0000, "R3");
        wr_idx('h18, 64'h0, "R3");
        read_all("R3");

        // R4: clear aliases
        for (int i = 0; i < 6; i++) wr_idx('h20 + i, 64'hFFFF_0000_0000_FFFF >> i, "R4");
        wr_idx('h28, 64'h0000_0000_0000_0F00, "R4");
        wr_idx('h29, '1, "R4");
        wr_idx('h20, 64'h0, "R4");
        read_all("R4");

        // R5: alias reads return ones and change nothing
        for (int i = 0; i < 6; i++) begin
            rd_idx('h10 + i, "R5");
            rd_idx('h20 + i, "R5");
        end
        rd_idx('h18, "R5"); rd_idx('h19, "R5");
        rd_idx('h28, "R5"); rd_idx('h29, "R5");
        read_all("R5");

        // R6: unmapped reads
        rd_idx('h06, "R6"); rd_idx('h07, "R6"); rd_idx('h0A, "R6");
        rd_idx('h16, "R6"); rd_idx('h2A, "R6"); rd_idx('h30, "R6");
        rd_idx('h102, "R6"); rd_idx('h3FD, "R6"); rd_idx('h400, "R6");
        access(1'b0, 64'h8000_0000_0000_0000, '0, "R6");

        // R7: unmapped writes are dropped
        wr_idx('h06, '1, "R7"); wr_idx('h2A, '1, "R7");
        wr_idx('h400, '1, "R7"); wr_idx('h1A, '1, "R7");
        access(1'b1, 64'h1000_0000_0000_0000, '1, "R7");
        read_all("R7");

        // R8: misaligned addresses behave as unmapped
        access(1'b0, 64'h41, '0, "R8");
        access(1'b0, 64'h0C, '0, "R8");
        access(1'b1, 64'h44, '1, "R8");
        access(1'b1, 64'h1FFF, '1, "R8");
        access(1'b1, 64'h09, '1, "R8");
        read_all("R8");

        // R9: mixed traffic with gaps
        wr_idx('h100, 64'h1, "R9");
        idle(2);
        rd_idx('h100, "R9");
        idle(1);
        wr_idx('h3FF, 64'h77, "R9");
        rd_idx('h3FF, "R9");
        idle(1);
        rd_idx('h3FE, "R9");

        idle(4);
        done = 1'b1;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: %0d responses missing, expected 0", sb_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule